// File: doc/BRIEF.md
# Result Latency Scoreboard With Bypass

This block sits at the issue stage of a pipelined core and decides, one request per cycle, whether an instruction may issue. Each request carries an instruction class, an optional destination register and two source registers. The block remembers, for every architectural register, which class last wrote it and how many cycles have gone by since then. A request is stalled while either source is still in flight.

The wait depends on both ends of a dependence. Each producer class has a default latency. A small bypass table replaces that default for chosen producer/consumer class pairs, and a bypass value may be shorter or longer than the default. Integer divides also hold the second integer unit for a long, non-pipelined stretch. A second divide waits until that unit is free, while other integer work keeps issuing.

A request that is stalled changes nothing. The environment may present it again or replace it. A per-register ready vector, computed with default latencies, is exported for observation.

Top module: `lat_scoreboard`

## Requirements
- R1: After reset every bit of `readyMask` is 1, `stall` is 0 and `divBusy` is 0. Each register then counts as written by class 0 long ago.
- R2: Class codes on `issueClass`, with default latency in parentheses: 0 int (2), 1 compare or record-form add/logical (3), 2 record-form shift/extend (2), 3 load (4), 4 sign-extending load (5), 5 FP load (6), 6 vector load (6), 7 FP arithmetic (6), 8 FP compare (5), 9 FP divide (33), 10 FP square root (40), 11 8/16-bit multiply (4), 12 32-bit multiply (5), 13 64-bit multiply (7), 14 record-form 32-bit multiply (5), 15 record-form 64-bit multiply (7), 16 32-bit divide (36), 17 64-bit divide (68), 18 branch/CR op (2), 19 vector simple (2), 20 vector complex (5), 21 vector float (8), 22 vector permute (2). Codes 23 to 31 act as class 0. An accepted producer issued in cycle t satisfies a consumer from cycle t+L onward, where L is the pair latency.
- R3: These pair latencies replace the default: 2→18 is 4, 14→18 is 8, 15→18 is 10, 21→22 is 9, 19→22 is 3, 20→22 is 6, 6→22 is 4, and 22→19, 22→20 and 22→21 are each 3. All other pairs use the producer's default.
- R4: `stall` is 1 exactly when `issueValid` is 1 and some source is not ready, or when the request is a divide (class 16 or 17) while `divBusy` is 1. A stalled request updates no register and does not start a divide.
- R5: An accepted write to a register still in flight takes effect only if its default latency is at least the cycles the old result still needs under its own default. Otherwise the old entry is kept.
- R6: A 32-bit divide accepted in cycle t drives `divBusy` high in cycles t+1 through t+DIV32_OCC-1. Another divide is stalled in that window, but non-divide requests are not held by it.
- R7: A 64-bit divide occupies the unit in the same way for DIV64_OCC cycles.
- R8: `readyMask[r]` is 1 when register r has aged at least the default latency of its last writer's class.
- R9: A request with `issueDstEn` low updates no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Issue request present |
| issueClass | input | 5 | Instruction class code |
| issueDstEn | input | 1 | Request writes a destination |
| issueDst | input | log2(NUM_REGS) | Destination register |
| issueSrcA | input | log2(NUM_REGS) | First source register |
| issueSrcB | input | log2(NUM_REGS) | Second source register |
| stall | output | 1 | Request must not issue this cycle |
| divBusy | output | 1 | Integer unit 2 held by a divide |
| readyMask | output | NUM_REGS | Per-register ready under default latency |

## Verification
The bench builds the block with 16 registers and shortens the divide occupancies to 12 and 20 cycles. With these values, random traffic on a small register file makes back-to-back dependences and divide collisions frequent. It also lets the release edge of both divide windows be reached many times within the run. The result latencies, including the 36- and 68-cycle divides and the 40-cycle square root, keep their fixed values.

// File: rtl/lat_sb_pkg.sv
package lat_sb_pkg;

  localparam int LAT_W = 7;

  typedef enum logic [4:0] {
    C_INT      = 5'd0,  C_CMPREC  = 5'd1,  C_SHREC   = 5'd2,  C_LOAD   = 5'd3,
    C_LOADEXT  = 5'd4,  C_LOADFP  = 5'd5,  C_LOADVEC = 5'd6,  C_FP     = 5'd7,
    C_FPCMP    = 5'd8,  C_FPDIV   = 5'd9,  C_FPSQRT  = 5'd10, C_MUL16  = 5'd11,
    C_MUL32    = 5'd12, C_MUL64   = 5'd13, C_MUL32R  = 5'd14, C_MUL64R = 5'd15,
    C_DIV32    = 5'd16, C_DIV64   = 5'd17, C_BRCR    = 5'd18, C_VSIMP  = 5'd19,
    C_VCPLX    = 5'd20, C_VFLT    = 5'd21, C_VPERM   = 5'd22
  } sbClass_t;

  // control-to-table strobes
  typedef struct packed {
    logic wrDst;
    logic divStart32;
    logic divStart64;
  } sbStrobe_t;

  function automatic logic [LAT_W-1:0] latDefault(input sbClass_t c);
    case (c)
      C_CMPREC:                    return 7'd3;
      C_LOAD, C_MUL16:             return 7'd4;
      C_LOADEXT, C_FPCMP, C_MUL32,
      C_MUL32R, C_VCPLX:           return 7'd5;
      C_LOADFP, C_LOADVEC, C_FP:   return 7'd6;
      C_MUL64, C_MUL64R:           return 7'd7;
      C_VFLT:                      return 7'd8;
      C_FPDIV:                     return 7'd33;
      C_DIV32:                     return 7'd36;
      C_FPSQRT:                    return 7'd40;
      C_DIV64:                     return 7'd68;
      default:                     return 7'd2;
    endcase
  endfunction

  function automatic logic [LAT_W-1:0] latPair(input sbClass_t p, input sbClass_t c);
    logic [LAT_W-1:0] lat;
    lat = latDefault(p);
    if (c == C_BRCR) begin
      if (p == C_SHREC)  lat = 7'd4;
      if (p == C_MUL32R) lat = 7'd8;
      if (p == C_MUL64R) lat = 7'd10;
    end
    if (c == C_VPERM) begin
      if (p == C_VFLT)    lat = 7'd9;
      if (p == C_VSIMP)   lat = 7'd3;
      if (p == C_VCPLX)   lat = 7'd6;
      if (p == C_LOADVEC) lat = 7'd4;
    end
    if (p == C_VPERM && (c == C_VSIMP || c == C_VCPLX || c == C_VFLT)) lat = 7'd3;
    return lat;
  endfunction

  function automatic logic isDivCls(input sbClass_t c);
    return (c == C_DIV32) || (c == C_DIV64);
  endfunction

endpackage

// File: rtl/lat_sb_table.sv
module lat_sb_table
  import lat_sb_pkg::*;
#(
  parameter int NUM_REGS = 64,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  sbStrobe_t           strobe,
  input  sbClass_t            consCls,
  input  logic [REG_W-1:0]    dst,
  input  logic [REG_W-1:0]    srcA,
  input  logic [REG_W-1:0]    srcB,
  output logic                srcReadyA,
  output logic                srcReadyB,
  output logic [NUM_REGS-1:0] readyMask
);

  localparam logic [LAT_W-1:0] AGE_MAX = '1;

  logic [LAT_W-1:0] ageQ [NUM_REGS];
  sbClass_t         clsQ [NUM_REGS];

  logic [LAT_W-1:0] oldLat, oldAge, oldRem, newLat;
  logic             takeWrite;

  assign srcReadyA = ageQ[srcA] >= latPair(clsQ[srcA], consCls);
  assign srcReadyB = ageQ[srcB] >= latPair(clsQ[srcB], consCls);

  // later-of rule for a rewrite of an in-flight register
  always_comb begin
    oldLat    = latDefault(clsQ[dst]);
    oldAge    = ageQ[dst];
    oldRem    = (oldAge >= oldLat) ? '0 : oldLat - oldAge;
    newLat    = latDefault(consCls);
    takeWrite = strobe.wrDst && (newLat >= oldRem);
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ageQ[g] <= AGE_MAX;
        clsQ[g] <= C_INT;
      end else if (takeWrite && dst == REG_W'(g)) begin
        ageQ[g] <= LAT_W'(1);
        clsQ[g] <= consCls;
      end else if (ageQ[g] != AGE_MAX) begin
        ageQ[g] <= ageQ[g] + LAT_W'(1);
      end
    end
    assign readyMask[g] = ageQ[g] >= latDefault(clsQ[g]);
  end

endmodule

// File: rtl/lat_sb_ctrl.sv
module lat_sb_ctrl
  import lat_sb_pkg::*;
#(
  parameter int DIV32_OCC = 35,
  parameter int DIV64_OCC = 67,
  localparam int CNT_W = $clog2(DIV64_OCC + 1)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      issueValid,
  input  sbClass_t  cls,
  input  logic      dstEn,
  input  logic      srcReadyA,
  input  logic      srcReadyB,
  output logic      stall,
  output logic      divBusy,
  output sbStrobe_t strobe
);

  logic [CNT_W-1:0] divCnt;
  logic             isDiv, accept;

  assign isDiv   = isDivCls(cls);
  assign divBusy = divCnt != '0;
  assign stall   = issueValid && (!srcReadyA || !srcReadyB || (isDiv && divBusy));
  assign accept  = issueValid && !stall;

  always_comb begin
    strobe.wrDst      = accept && dstEn;
    strobe.divStart32 = accept && cls == C_DIV32;
    strobe.divStart64 = accept && cls == C_DIV64;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  divCnt <= '0;
    else if (strobe.divStart32) divCnt <= CNT_W'(DIV32_OCC - 1);
    else if (strobe.divStart64) divCnt <= CNT_W'(DIV64_OCC - 1);
    else if (divCnt != '0)      divCnt <= divCnt - CNT_W'(1);
  end

endmodule

// File: rtl/lat_scoreboard.sv
module lat_scoreboard
  import lat_sb_pkg::*;
#(
  parameter int NUM_REGS  = 64,
  parameter int DIV32_OCC = 35,
  parameter int DIV64_OCC = 67,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                issueValid,
  input  logic [4:0]          issueClass,
  input  logic                issueDstEn,
  input  logic [REG_W-1:0]    issueDst,
  input  logic [REG_W-1:0]    issueSrcA,
  input  logic [REG_W-1:0]    issueSrcB,
  output logic                stall,
  output logic                divBusy,
  output logic [NUM_REGS-1:0] readyMask
);

  sbClass_t  cls;
  sbStrobe_t strobe;
  logic      srcReadyA, srcReadyB;

  assign cls = sbClass_t'(issueClass);

  lat_sb_ctrl #(.DIV32_OCC(DIV32_OCC), .DIV64_OCC(DIV64_OCC)) u_ctrl (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .cls(cls),
    .dstEn(issueDstEn), .srcReadyA(srcReadyA), .srcReadyB(srcReadyB),
    .stall(stall), .divBusy(divBusy), .strobe(strobe)
  );

  lat_sb_table #(.NUM_REGS(NUM_REGS)) u_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .consCls(cls),
    .dst(issueDst), .srcA(issueSrcA), .srcB(issueSrcB),
    .srcReadyA(srcReadyA), .srcReadyB(srcReadyB), .readyMask(readyMask)
  );

endmodule

// File: rtl/lat_sb_check.sv
module lat_sb_check #(
  parameter int NUM_REGS = 64,
  localparam int REG_W = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                issueValid,
  input logic [4:0]          issueClass,
  input logic                issueDstEn,
  input logic [REG_W-1:0]    issueDst,
  input logic                stall,
  input logic                divBusy,
  input logic [NUM_REGS-1:0] readyMask
);

  logic reqDiv;
  assign reqDiv = issueValid && (issueClass == 5'd16 || issueClass == 5'd17);

  p_stall_needs_req_r4: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> issueValid);

  p_div_blocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqDiv && divBusy) |-> stall);

  p_div_claims_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqDiv && !stall) |=> divBusy);

  p_write_pending_r2: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid && !stall && issueDstEn && !readyMask[issueDst])
      |=> !readyMask[$past(issueDst)]);

endmodule

bind lat_scoreboard lat_sb_check #(.NUM_REGS(NUM_REGS)) u_lat_sb_check (
  .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueClass(issueClass),
  .issueDstEn(issueDstEn), .issueDst(issueDst), .stall(stall),
  .divBusy(divBusy), .readyMask(readyMask)
);

// File: tb/lat_scoreboard_bench.sv
module lat_scoreboard_bench;

  localparam int NR   = 16;
  localparam int RW   = 4;
  localparam int OCC32 = 12;
  localparam int OCC64 = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          issueValid = 1'b0;
  logic [4:0]    issueClass = '0;
  logic          issueDstEn = 1'b0;
  logic [RW-1:0] issueDst = '0, issueSrcA = '0, issueSrcB = '0;
  logic          stall, divBusy;
  logic [NR-1:0] readyMask;

  int checks = 0, fails = 0, cyc = 0;
  int regIssue [NR];
  int regCls   [NR];
  int divUntil = -1000;
  logic lastStall;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lat_scoreboard #(.NUM_REGS(NR), .DIV32_OCC(OCC32), .DIV64_OCC(OCC64)) u_lat_scoreboard (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueClass(issueClass),
    .issueDstEn(issueDstEn), .issueDst(issueDst), .issueSrcA(issueSrcA),
    .issueSrcB(issueSrcB), .stall(stall), .divBusy(divBusy), .readyMask(readyMask)
  );

  function automatic int defLat(int c);
    case (c)
      1: return 3;  3, 11: return 4;  4, 8, 12, 14, 20: return 5;
      5, 6, 7: return 6;  13, 15: return 7;  21: return 8;  9: return 33;
      16: return 36;  10: return 40;  17: return 68;  default: return 2;
    endcase
  endfunction

  function automatic int pairLat(int p, int c);
    if (p == 2  && c == 18) return 4;
    if (p == 14 && c == 18) return 8;
    if (p == 15 && c == 18) return 10;
    if (p == 21 && c == 22) return 9;
    if (p == 19 && c == 22) return 3;
    if (p == 20 && c == 22) return 6;
    if (p == 6  && c == 22) return 4;
    if (p == 22 && (c == 19 || c == 20 || c == 21)) return 3;
    return defLat(p);
  endfunction

  function automatic int normCls(int c);
    return (c > 22) ? 0 : c;
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(bit v, int c, int d, bit en, int a, int b, string tag);
    logic [NR-1:0] expMask;
    bit expStall, busy, rdyA, rdyB;
    int cc;
    @(negedge clk);
    issueValid = v; issueClass = 5'(c); issueDstEn = en;
    issueDst = RW'(d); issueSrcA = RW'(a); issueSrcB = RW'(b);
    #1;
    cc   = normCls(c);
    busy = cyc < divUntil;
    rdyA = (cyc - regIssue[a]) >= pairLat(regCls[a], cc);
    rdyB = (cyc - regIssue[b]) >= pairLat(regCls[b], cc);
    expStall = v && (!rdyA || !rdyB || ((cc == 16 || cc == 17) && busy));
    for (int r = 0; r < NR; r++) expMask[r] = (cyc - regIssue[r]) >= defLat(regCls[r]);
    check(stall == expStall, tag, "stall", int'(stall), int'(expStall));
    check(divBusy == busy, "R6", "divBusy", int'(divBusy), int'(busy));
    check(readyMask == expMask, "R8", "readyMask", int'(readyMask), int'(expMask));
    lastStall = stall;
    if (v && !expStall) begin
      if (en) begin
        int rem;
        rem = defLat(regCls[d]) - (cyc - regIssue[d]);
        if (rem < 0) rem = 0;
        if (defLat(cc) >= rem) begin regIssue[d] = cyc; regCls[d] = cc; end
      end
      if (cc == 16) divUntil = cyc + OCC32;
      if (cc == 17) divUntil = cyc + OCC64;
    end
  endtask

  task automatic issueUntil(int c, int d, bit en, int a, int b, string tag, output int waited);
    waited = 0;
    step(1, c, d, en, a, b, tag);
    while (lastStall && waited < 200) begin
      waited++;
      step(1, c, d, en, a, b, tag);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, "R2");
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int w;
    int seed;
    for (int r = 0; r < NR; r++) begin regIssue[r] = -1000; regCls[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    // R1 reset state
    check(readyMask == '1, "R1", "readyMask", int'(readyMask), 'hffff);
    check(!stall, "R1", "stall", int'(stall), 0);
    check(!divBusy, "R1", "divBusy", int'(divBusy), 0);

    // R2 integer producer: consumer waits exactly 2 cycles
    step(1, 0, 8, 1, 9, 10, "R2");
    issueUntil(0, 11, 1, 8, 8, "R2", w);
    check(w == 1, "R2", "int wait", w, 1);
    // R2 64-bit multiply default 7
    step(1, 13, 8, 1, 9, 10, "R2");
    issueUntil(19, 12, 1, 8, 9, "R2", w);
    check(w == 6, "R2", "mul64 wait", w, 6);

    // R3 record shift to branch needs 4, to int only 2
    idle(10);
    step(1, 2, 9, 1, 10, 10, "R3");
    issueUntil(18, 13, 0, 9, 9, "R3", w);
    check(w == 3, "R3", "shrec->branch wait", w, 3);
    // R3 vector load to permute: 4, shorter than default 6
    step(1, 6, 10, 1, 11, 11, "R3");
    issueUntil(22, 14, 1, 10, 11, "R3", w);
    check(w == 3, "R3", "vload->perm wait", w, 3);
    // R3 permute to vector float 3
    issueUntil(21, 15, 1, 14, 14, "R3", w);
    check(w == 2, "R3", "perm->vfloat wait", w, 2);

    // R5 long sqrt then short int rewrite: old entry kept
    idle(10);
    step(1, 10, 11, 1, 12, 12, "R5");
    step(1, 0, 11, 1, 12, 12, "R5");
    idle(3);
    check(!readyMask[11], "R5", "kept sqrt", int'(readyMask[11]), 0);
    // short then long rewrite: new entry wins
    step(1, 0, 12, 1, 13, 13, "R5");
    step(1, 7, 12, 1, 13, 13, "R5");
    idle(2);
    check(!readyMask[12], "R5", "took fp", int'(readyMask[12]), 0);

    // R4 stalled request leaves destination untouched
    idle(50);
    step(1, 7, 13, 1, 14, 14, "R4");
    step(1, 0, 14, 1, 13, 13, "R4");
    check(lastStall, "R4", "dep stall", int'(lastStall), 1);
    step(0, 0, 0, 0, 0, 0, "R4");
    check(readyMask[14], "R4", "dst untouched", int'(readyMask[14]), 1);

    // R6 divide occupancy, int work unaffected
    idle(10);
    step(1, 16, 15, 1, 8, 8, "R6");
    step(1, 0, 9, 1, 8, 8, "R6");
    check(!lastStall, "R6", "int during div", int'(lastStall), 0);
    issueUntil(16, 10, 1, 8, 8, "R6", w);
    check(w == OCC32 - 2, "R6", "div32 release", w, OCC32 - 2);
    // R7 64-bit divide
    idle(OCC32 + 2);
    step(1, 17, 11, 1, 8, 8, "R7");
    issueUntil(17, 12, 1, 8, 8, "R7", w);
    check(w == OCC64 - 1, "R7", "div64 release", w, OCC64 - 1);

    // R9 no destination write
    idle(80);
    step(1, 13, 8, 0, 9, 9, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");
    check(readyMask[8], "R9", "no write", int'(readyMask[8]), 1);

    // random traffic
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < 4000; i++) begin
      int c;
      c = ($urandom % 8 == 0) ? int'($urandom % 32) : int'($urandom % 23);
      step($urandom % 4 != 0, c, int'($urandom % NR), $urandom % 5 != 0,
           int'($urandom % NR), int'($urandom % NR), "R2 R3 R4 R5");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule